// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction RISC Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It supports a fixed set of nine operations: load word, store word, register-to-register add, subtract, bitwise AND, bitwise OR, signed set-on-less-than, branch-if-equal and an unconditional jump. The core fetches an instruction word through an instruction port. It decodes the word, reads two operands from a 32-entry register file, runs the ALU, optionally accesses data memory, and writes the result back. All of this happens before the next rising edge.

Both memories sit outside the core and must answer reads combinationally. The core drives a byte address and expects the word selected by address bits 9 to 2 to come back in the same cycle. The data memory takes a store on the rising edge that ends the store cycle. A main decoder produces a small bundle of strobes that drives the datapath. A second decoder turns the operation class and the function field into a 4-bit ALU selection.

Top module: `sc9_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears all 32 registers to zero. After release, the first fetch is from address 0.
- R2: `imemAddr` always equals the program counter. An instruction that is neither a taken branch nor a jump advances it by 4.
- R3: Load word (opcode bits [31:26] = 100011) raises `dmemRd`. It drives `dmemAddr` = rs (bits [25:21]) + sign-extended bits [15:0], and writes `dmemRdata` into register rt (bits [20:16]).
- R4: Store word (opcode 101011) raises `dmemWr` with `dmemMask` = 1111. It drives `dmemAddr` = rs + sign-extended immediate and `dmemWdata` = register rt, and writes no register.
- R5: Opcode 000000 writes register rd (bits [15:11]). The function field bits [5:0] select the operation: 100000 gives rs+rt, 100010 gives rs−rt, 100100 gives rs AND rt, and 100101 gives rs OR rt.
- R6: Function 101010 under opcode 000000 writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R7: Register 0 always reads as zero, and writes addressed to it have no effect.
- R8: Branch-if-equal (opcode 000100) compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, which covers backward offsets as well. Otherwise the next PC is PC+4.
- R9: Jump (opcode 000010) loads the PC with {PC[31:28], bits [25:0], 00}. It writes no register and does not touch memory.
- R10: `dmemRd` and `dmemWr` are never high together. `dmemWr` is high only for store word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 32 | Byte address of the instruction being executed |
| imemData | input | 32 | Instruction word returned for `imemAddr` |
| dmemAddr | output | 32 | Byte address for a load or store |
| dmemRd | output | 1 | High during a load |
| dmemWr | output | 1 | High during a store, taken at the next rising edge |
| dmemMask | output | 4 | Byte enables for a store |
| dmemWdata | output | 32 | Store data |
| dmemRdata | input | 32 | Word returned for `dmemAddr` |

## Verification
On every cycle, the embedded assertions check the PC update rules: reset to zero, advance by 4 when no branch is taken, and take the jump target. They also check that register 0 reads as zero, that the memory strobes never overlap, and that a store never enables a register write. Only the bench's program can show that values actually travel through the register file and the ALU into memory. The program does this by storing each result and comparing the stored words. It also covers the signed-versus-unsigned distinction in set-on-less-than, instructions skipped by a taken forward branch and by a jump, and a backward branch that settles into a self-loop.

// File: rtl/sc9_pkg.sv
package sc9_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OPC_ALU   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BREQ  = 6'b000100;
  localparam logic [5:0] OPC_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_sel_e;

  typedef struct packed {
    logic     regDst;
    logic     aluSrc;
    logic     memToReg;
    logic     regWrite;
    logic     memRead;
    logic     memWrite;
    logic     branch;
    logic     jump;
    alu_sel_e aluSel;
  } ctrl_t;
endpackage

// File: rtl/sc9_control.sv
module sc9_control
  import sc9_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  logic [1:0] aluClass;
  ctrl_t      c;

  always_comb begin
    c        = '0;
    c.aluSel = ALU_ADD;
    aluClass = 2'b00;
    case (opcode)
      OPC_ALU: begin
        c.regDst = 1'b1; c.regWrite = 1'b1; aluClass = 2'b10;
      end
      OPC_LOAD: begin
        c.aluSrc = 1'b1; c.memToReg = 1'b1; c.regWrite = 1'b1; c.memRead = 1'b1;
      end
      OPC_STORE: begin
        c.aluSrc = 1'b1; c.memWrite = 1'b1;
      end
      OPC_BREQ: begin
        c.branch = 1'b1; aluClass = 2'b01;
      end
      OPC_JMP: c.jump = 1'b1;
      default: ;
    endcase

    case (aluClass)
      2'b01:   c.aluSel = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_SUB:  c.aluSel = ALU_SUB;
          FN_AND:  c.aluSel = ALU_AND;
          FN_OR:   c.aluSel = ALU_OR;
          FN_SLT:  c.aluSel = ALU_SLT;
          default: c.aluSel = ALU_ADD;
        endcase
      end
      default: c.aluSel = ALU_ADD;
    endcase
    ctrl = c;
  end

  // R10
  always_comb begin
    strobe_excl_chk: assert (!(ctrl.memRead && ctrl.memWrite));
  end
endmodule

// File: rtl/sc9_regfile.sv
module sc9_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    raA,
  input  logic [AW-1:0]    raB,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] rdA,
  output logic [WIDTH-1:0] rdB
);
  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rdA = regs[raA];
  assign rdB = regs[raB];

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (raA == '0) |-> (rdA == '0));
endmodule

// File: rtl/sc9_alu.sv
module sc9_alu
  import sc9_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_sel_e         sel,
  output logic [WIDTH-1:0] res,
  output logic             zero
);
  always_comb begin
    case (sel)
      ALU_AND: res = opA & opB;
      ALU_OR:  res = opA | opB;
      ALU_ADD: res = opA + opB;
      ALU_SUB: res = opA - opB;
      ALU_SLT: res = {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: res = '0;
    endcase
  end
  assign zero = (res == '0);
endmodule

// File: rtl/sc9_datapath.sv
module sc9_datapath
  import sc9_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  input  logic [25:0]     instrLo,
  input  logic [XLEN-1:0] dmemRdata,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] dmemAddr,
  output logic            dmemRd,
  output logic            dmemWr,
  output logic [3:0]      dmemMask,
  output logic [XLEN-1:0] dmemWdata
);
  localparam int IMMW = 16;

  logic [XLEN-1:0]   pcQ, pcNext, pcPlus4, brTarget, jmpTarget, immExt;
  logic [XLEN-1:0]   rdA, rdB, aluB, aluRes, wrData;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic              aluZero, takeBr;

  assign rsIdx  = instrLo[25:21];
  assign rtIdx  = instrLo[20:16];
  assign rdIdx  = instrLo[15:11];
  assign immExt = {{(XLEN-IMMW){instrLo[IMMW-1]}}, instrLo[IMMW-1:0]};

  assign pcPlus4   = pcQ + XLEN'(4);
  assign brTarget  = pcPlus4 + (immExt << 2);
  assign jmpTarget = {pcQ[XLEN-1:XLEN-4], instrLo, 2'b00};
  assign takeBr    = ctrl.branch & aluZero;

  always_comb begin
    if (ctrl.jump)   pcNext = jmpTarget;
    else if (takeBr) pcNext = brTarget;
    else             pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  assign wrIdx  = ctrl.regDst   ? rdIdx     : rtIdx;
  assign aluB   = ctrl.aluSrc   ? immExt    : rdB;
  assign wrData = ctrl.memToReg ? dmemRdata : aluRes;

  sc9_regfile #(.WIDTH(XLEN), .DEPTH(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .raA (rsIdx),
    .raB (rtIdx),
    .we  (ctrl.regWrite),
    .wa  (wrIdx),
    .wd  (wrData),
    .rdA (rdA),
    .rdB (rdB)
  );

  sc9_alu #(.WIDTH(XLEN)) u_alu (
    .opA  (rdA),
    .opB  (aluB),
    .sel  (ctrl.aluSel),
    .res  (aluRes),
    .zero (aluZero)
  );

  assign pcOut     = pcQ;
  assign dmemAddr  = aluRes;
  assign dmemWdata = rdB;
  assign dmemRd    = ctrl.memRead;
  assign dmemWr    = ctrl.memWrite;
  assign dmemMask  = {4{ctrl.memWrite}};

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pcQ == '0));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !ctrl.branch) |=> (pcQ == $past(pcQ) + XLEN'(4)));
  // R8
  br_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && (rdA != rdB)) |=> (pcQ == $past(pcQ) + XLEN'(4)));
  // R9
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pcQ[27:0] == {$past(instrLo), 2'b00}));
  // R4
  store_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    dmemWr |-> (!ctrl.regWrite && dmemMask == 4'hF));
endmodule

// File: rtl/sc9_core.sv
module sc9_core
  import sc9_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imemAddr,
  input  logic [31:0] imemData,
  output logic [31:0] dmemAddr,
  output logic        dmemRd,
  output logic        dmemWr,
  output logic [3:0]  dmemMask,
  output logic [31:0] dmemWdata,
  input  logic [31:0] dmemRdata
);
  ctrl_t ctrl;

  sc9_control u_ctrl (
    .opcode (imemData[31:26]),
    .funct  (imemData[5:0]),
    .ctrl   (ctrl)
  );

  sc9_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .instrLo   (imemData[25:0]),
    .dmemRdata (dmemRdata),
    .pcOut     (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemRd    (dmemRd),
    .dmemWr    (dmemWr),
    .dmemMask  (dmemMask),
    .dmemWdata (dmemWdata)
  );
endmodule

// File: tb/sc9_core_tb.sv
module sc9_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemRd, dmemWr;
  logic [3:0]  dmemMask;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int nRun  = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  sc9_core u_dut (
    .clk(clk), .rst(rst),
    .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemRd(dmemRd), .dmemWr(dmemWr),
    .dmemMask(dmemMask), .dmemWdata(dmemWdata), .dmemRdata(dmemRdata)
  );

  assign imemData  = imem[imemAddr[9:2]];
  assign dmemRdata = dmem[dmemAddr[9:2]];

  function automatic logic [31:0] rIns(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction
  function automatic logic [31:0] iIns(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BQ = 6'b000100;

  // Stored result table: {word index, requirement, expected word}
  localparam int NEXP = 14;
  localparam logic [47:0] EXP [NEXP] = '{
    {8'd17, 8'd1, 32'h0000_0000},  // R1: register cleared by reset
    {8'd4,  8'd5, 32'h0000_0002},  // R5: add
    {8'd5,  8'd5, 32'h0000_0008},  // R5: sub
    {8'd6,  8'd5, 32'h0000_0004},  // R5: and
    {8'd7,  8'd5, 32'h0000_0F0D},  // R5: or
    {8'd8,  8'd6, 32'h0000_0001},  // R6: -3 < 5
    {8'd9,  8'd6, 32'h0000_0000},  // R6: 5 < -3 false when signed
    {8'd10, 8'd7, 32'h0000_0000},  // R7: write to register 0 ignored
    {8'd11, 8'd8, 32'h1111_1111},  // R8: skipped by taken branch
    {8'd12, 8'd8, 32'h2222_2222},  // R8
    {8'd13, 8'd9, 32'h3333_3333},  // R9: skipped by jump
    {8'd14, 8'd9, 32'h4444_4444},  // R9
    {8'd15, 8'd3, 32'hFFFF_FFFD},  // R3: loaded value stored back
    {8'd16, 8'd5, 32'h0000_0000}   // R5: sub to zero
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: preload, then take stores
  initial begin
    for (int i = 0; i < 256; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    dmem[0] = 32'd5; dmem[1] = 32'hFFFF_FFFD; dmem[2] = 32'h0000_0F0C;
    dmem[11] = 32'h1111_1111; dmem[12] = 32'h2222_2222;
    dmem[13] = 32'h3333_3333; dmem[14] = 32'h4444_4444;
    dmem[17] = 32'h5555_5555;
    imem[0]  = iIns(SW, 5'd0, 5'd11, 16'd68);
    imem[1]  = iIns(LW, 5'd0, 5'd1, 16'd0);
    imem[2]  = iIns(LW, 5'd0, 5'd2, 16'd4);
    imem[3]  = iIns(LW, 5'd0, 5'd7, 16'd8);
    imem[4]  = rIns(5'd1, 5'd2, 5'd3, 6'b100000);
    imem[5]  = rIns(5'd1, 5'd2, 5'd4, 6'b100010);
    imem[6]  = rIns(5'd1, 5'd7, 5'd5, 6'b100100);
    imem[7]  = rIns(5'd1, 5'd7, 5'd6, 6'b100101);
    imem[8]  = rIns(5'd2, 5'd1, 5'd8, 6'b101010);
    imem[9]  = rIns(5'd1, 5'd2, 5'd9, 6'b101010);
    imem[10] = rIns(5'd1, 5'd1, 5'd0, 6'b100000);
    imem[11] = iIns(SW, 5'd0, 5'd3, 16'd16);
    imem[12] = iIns(SW, 5'd0, 5'd4, 16'd20);
    imem[13] = iIns(SW, 5'd0, 5'd5, 16'd24);
    imem[14] = iIns(SW, 5'd0, 5'd6, 16'd28);
    imem[15] = iIns(SW, 5'd0, 5'd8, 16'd32);
    imem[16] = iIns(SW, 5'd0, 5'd9, 16'd36);
    imem[17] = iIns(SW, 5'd0, 5'd0, 16'd40);
    imem[18] = iIns(BQ, 5'd1, 5'd2, 16'd5);
    imem[19] = iIns(BQ, 5'd1, 5'd1, 16'd2);
    imem[20] = iIns(SW, 5'd0, 5'd1, 16'd44);
    imem[21] = iIns(SW, 5'd0, 5'd1, 16'd48);
    imem[22] = {6'b000010, 26'd25};
    imem[23] = iIns(SW, 5'd0, 5'd1, 16'd52);
    imem[24] = iIns(SW, 5'd0, 5'd1, 16'd56);
    imem[25] = iIns(SW, 5'd0, 5'd2, 16'd60);
    imem[26] = rIns(5'd1, 5'd1, 5'd10, 6'b100010);
    imem[27] = iIns(SW, 5'd0, 5'd10, 16'd64);
    imem[28] = iIns(BQ, 5'd10, 5'd0, 16'hFFFF);
    forever begin
      @(posedge clk);
      if (dmemWr) dmem[dmemAddr[9:2]] <= dmemWdata;
    end
  end

  initial begin
    bit saw72, saw76, sawBrSkip, sawJmpSkip, badMask, bothStrobe;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: PC at zero under reset
    check(imemAddr == 32'h0, "R1 reset pc", imemAddr, 32'h0);
    rst = 1'b0;
    #1;
    // R4: first instruction stores cleared register 11 to byte 68
    check(dmemWr === 1'b1 && dmemRd === 1'b0, "R4 store strobe", {30'b0, dmemWr, dmemRd}, 32'h2);
    check(dmemAddr == 32'd68, "R4 store address", dmemAddr, 32'd68);
    check(dmemMask == 4'hF, "R4 store mask", {28'b0, dmemMask}, 32'hF);
    @(negedge clk);
    // R2 and R3: next fetch and load strobes
    check(imemAddr == 32'd4, "R2 pc step", imemAddr, 32'd4);
    check(dmemRd === 1'b1 && dmemWr === 1'b0, "R3 load strobe", {30'b0, dmemWr, dmemRd}, 32'h1);
    check(dmemAddr == 32'd0, "R3 load address", dmemAddr, 32'd0);
    for (int c = 0; c < 45; c++) begin
      @(negedge clk);
      if (imemAddr == 32'd72) saw72 = 1'b1;
      if (imemAddr == 32'd76) saw76 = 1'b1;
      if (imemAddr == 32'd80 || imemAddr == 32'd84) sawBrSkip = 1'b1;
      if (imemAddr == 32'd92 || imemAddr == 32'd96) sawJmpSkip = 1'b1;
      if (dmemWr && dmemMask != 4'hF) badMask = 1'b1;
      if (dmemWr && dmemRd) bothStrobe = 1'b1;
    end
    check(saw72 && saw76, "R8 untaken branch falls through", {30'b0, saw72, saw76}, 32'h3);
    check(!sawBrSkip, "R8 taken branch skips", {31'b0, sawBrSkip}, 32'h0);
    check(!sawJmpSkip, "R9 jump skips", {31'b0, sawJmpSkip}, 32'h0);
    check(!badMask, "R4 mask on every store", {31'b0, badMask}, 32'h0);
    check(!bothStrobe, "R10 strobes exclusive", {31'b0, bothStrobe}, 32'h0);
    // R8: backward branch self-loop
    check(imemAddr == 32'd112, "R8 backward branch", imemAddr, 32'd112);
    check(dmemWr === 1'b0, "R10 no store in loop", {31'b0, dmemWr}, 32'h0);
    for (int k = 0; k < NEXP; k++) begin
      logic [7:0]  idx;
      logic [31:0] exp;
      string       tag;
      idx = EXP[k][47:40];
      exp = EXP[k][31:0];
      tag = $sformatf("R%0d word %0d", EXP[k][39:32], idx);
      check(dmem[idx] == exp, tag, dmem[idx], exp);
    end
    // R1: second reset returns PC to zero
    rst = 1'b1;
    @(negedge clk);
    check(imemAddr == 32'h0, "R1 re-reset pc", imemAddr, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule